// File: doc/BRIEF.md
# Dual-Input Decade Up/Down Counter

This block is a single BCD digit (values 0 to 9) that counts up on a rising edge of one count input and down on a rising edge of a second count input; there is no direction pin. A step in one direction is taken only while the opposite count input rests high. The digit can be cleared by an active-high clear input and loaded from a 4-bit preset word by an active-low load input. Clear wins over load, and load wins over counting.

One system clock runs the whole block. The clear, load and both count inputs pass through two-flop synchronizers, and the rising edges of the count inputs are found on the synchronized levels. Two active-low terminal-count outputs, one per direction, are decoded from the registered count and the synchronized input levels. Wiring one digit's up terminal count to the next digit's up input, and its down terminal count to the next digit's down input, builds a multi-digit up/down counter.

When loaded with a code from 10 to 15, the digit finds its way back into the decade range. Counting up pairs the codes off and jumps back into the range. Counting down simply walks down through 9.

Top module: `decade_updown_counter`

## Requirements
- R1: While `rst` is high on a clock edge, the count becomes 0 and both terminal-count outputs read 1. All synchronized levels return to idle, which is clear 0, load 1, up 1 and down 1.
- R2: A rising edge on `up_i` while `dn_i` is high adds one to a count of 0 to 8, and a count of 9 goes to 0.
- R3: A rising edge on `dn_i` while `up_i` is high subtracts one from a count of 1 to 15, and a count of 0 goes to 9.
- R4: The count holds when neither count input rises, when a count input rises while the other is low, and when both rise in the same synchronized cycle.
- R5: `clr_i` high forces the count to 0 and overrides both load and counting.
- R6: With `clr_i` low and `load_n_i` low, the count takes the value of `preset_i` on every cycle, and count edges are ignored.
- R7: Counting up from an out-of-range code follows 10→11→6, 12→13→4 and 14→15→2.
- R8: Counting down from 15 steps through 14, 13, 12, 11 and 10 to 9, then continues in the decade.
- R9: `tc_up_n_o` is 0 exactly when the synchronized up level is low and count bits 0 and 3 are both 1 (count 9 in normal use).
- R10: `tc_dn_n_o` is 0 exactly when the synchronized down level is low and the count is 0.
- R11: Two digits chained through their terminal counts count as one two-digit decimal counter in both directions, including wrap past 99 and past 00.
- R12: A level change on any control input first affects the count on the third rising clock edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Active-high clear to zero |
| load_n_i | input | 1 | Active-low parallel load of `preset_i` |
| up_i | input | 1 | Count-up input, acts on its rising edge |
| dn_i | input | 1 | Count-down input, acts on its rising edge |
| preset_i | input | 4 | Value copied in during a load |
| count_o | output | 4 | Registered digit value, bit 0 is the LSB |
| tc_up_n_o | output | 1 | Active-low up terminal count |
| tc_dn_n_o | output | 1 | Active-low down terminal count |

## Verification
The count inputs are driven with single up pulses and single down pulses across the full decade and across both wraps. Separate patterns hold one count input low while the other is pulsed, and release both in the same cycle, which shows that the step gating and the simultaneous-edge hold are separate cases. Loads of every out-of-range code followed by up or down pulses distinguish the escape transitions from an ordinary increment or decrement. Clear asserted together with load and pulses shows the priority order. A second digit chained to the first checks that the terminal counts give exactly one carry or borrow per wrap.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
  localparam digit_t DIGIT_TOP = digit_t'(9);

  typedef struct packed {
    logic clr;
    logic load_n;
    logic up;
    logic dn;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
  localparam ctl_t CTL_IDLE = '{clr: 1'b0, load_n: 1'b1, up: 1'b1, dn: 1'b1};
endpackage

// File: rtl/ddc_sync.sv
module ddc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ddc_step.sv
module ddc_step
  import ddc_pkg::*;
(
  input  digit_t cur,
  input  logic   inc,
  input  logic   dec,
  output digit_t nxt
);
  digit_t up_val;
  digit_t dn_val;

  always_comb begin
    case (cur)
      DIGIT_TOP:    up_val = '0;
      digit_t'(11): up_val = digit_t'(6);
      digit_t'(13): up_val = digit_t'(4);
      digit_t'(15): up_val = digit_t'(2);
      default:      up_val = cur + digit_t'(1);
    endcase
  end

  always_comb begin
    if (cur == '0) dn_val = DIGIT_TOP;
    else           dn_val = cur - digit_t'(1);
  end

  always_comb begin
    if (inc)      nxt = up_val;
    else if (dec) nxt = dn_val;
    else          nxt = cur;
  end
endmodule

// File: rtl/ddc_tc.sv
module ddc_tc
  import ddc_pkg::*;
(
  input  digit_t cnt,
  input  logic   up_lvl,
  input  logic   dn_lvl,
  output logic   tc_up_n,
  output logic   tc_dn_n
);
  assign tc_up_n = ~(~up_lvl & cnt[0] & cnt[DIGIT_W-1]);
  assign tc_dn_n = ~(~dn_lvl & (cnt == '0));
endmodule

// File: rtl/decade_updown_counter.sv
module decade_updown_counter
  import ddc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic               load_n_i,
  input  logic               up_i,
  input  logic               dn_i,
  input  logic [DIGIT_W-1:0] preset_i,
  output logic [DIGIT_W-1:0] count_o,
  output logic               tc_up_n_o,
  output logic               tc_dn_n_o
);
  ctl_t   ctl_raw;
  ctl_t   ctl_s;
  logic   clr_lvl, load_n_lvl, up_lvl, dn_lvl;
  logic   up_prev, dn_prev;
  logic   up_rise, dn_rise;
  logic   do_inc, do_dec;
  digit_t cnt_q;
  digit_t cnt_step;

  assign ctl_raw = '{clr: clr_i, load_n: load_n_i, up: up_i, dn: dn_i};

  ddc_sync #(
    .W       (CTL_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (CTL_IDLE)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ctl_raw),
    .q   (ctl_s)
  );

  assign clr_lvl    = ctl_s.clr;
  assign load_n_lvl = ctl_s.load_n;
  assign up_lvl     = ctl_s.up;
  assign dn_lvl     = ctl_s.dn;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_prev <= 1'b1;
      dn_prev <= 1'b1;
    end else begin
      up_prev <= up_lvl;
      dn_prev <= dn_lvl;
    end
  end

  assign up_rise = up_lvl & ~up_prev;
  assign dn_rise = dn_lvl & ~dn_prev;
  assign do_inc  = up_rise & dn_lvl & ~dn_rise;
  assign do_dec  = dn_rise & up_lvl & ~up_rise;

  ddc_step u_step (
    .cur (cnt_q),
    .inc (do_inc),
    .dec (do_dec),
    .nxt (cnt_step)
  );

  always_ff @(posedge clk) begin
    if (rst || clr_lvl) cnt_q <= '0;
    else if (!load_n_lvl) cnt_q <= preset_i;
    else cnt_q <= cnt_step;
  end

  ddc_tc u_tc (
    .cnt     (cnt_q),
    .up_lvl  (up_lvl),
    .dn_lvl  (dn_lvl),
    .tc_up_n (tc_up_n_o),
    .tc_dn_n (tc_dn_n_o)
  );

  assign count_o = cnt_q;
endmodule

// File: rtl/ddc_counter_chk.sv
module ddc_counter_chk
  import ddc_pkg::*;
(
  input logic         clk,
  input logic         rst,
  input logic         clr_lvl,
  input logic         load_n_lvl,
  input logic         up_lvl,
  input logic         dn_lvl,
  input logic         up_prev,
  input logic         dn_prev,
  input logic [3:0]   preset_i,
  input logic [3:0]   count_o,
  input logic         tc_up_n_o,
  input logic         tc_dn_n_o
);
  logic quiet;
  assign quiet = !clr_lvl && load_n_lvl;

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (rst)
    clr_lvl |=> count_o == 4'd0);

  p_load_copy_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr_lvl && !load_n_lvl) |=> count_o == $past(preset_i));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (quiet && !(up_lvl && !up_prev) && !(dn_lvl && !dn_prev)) |=> $stable(count_o));

  p_both_rise_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (quiet && up_lvl && !up_prev && dn_lvl && !dn_prev) |=> $stable(count_o));

  p_up_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (quiet && up_lvl && !up_prev && dn_lvl && dn_prev && count_o == 4'd9) |=> count_o == 4'd0);

  p_dn_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (quiet && dn_lvl && !dn_prev && up_lvl && up_prev && count_o == 4'd0) |=> count_o == 4'd9);

  p_tc_up_idle_r9: assert property (@(posedge clk) disable iff (rst)
    up_lvl |-> tc_up_n_o);

  p_tc_dn_idle_r10: assert property (@(posedge clk) disable iff (rst)
    dn_lvl |-> tc_dn_n_o);
endmodule

bind decade_updown_counter ddc_counter_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr_lvl    (clr_lvl),
  .load_n_lvl (load_n_lvl),
  .up_lvl     (up_lvl),
  .dn_lvl     (dn_lvl),
  .up_prev    (up_prev),
  .dn_prev    (dn_prev),
  .preset_i   (preset_i),
  .count_o    (count_o),
  .tc_up_n_o  (tc_up_n_o),
  .tc_dn_n_o  (tc_dn_n_o)
);

// File: tb/decade_updown_counter_bench.sv
`timescale 1ns/1ps
module decade_updown_counter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0;
  logic       load_n = 1'b1;
  logic       up = 1'b1;
  logic       dn = 1'b1;
  logic [3:0] preset = 4'd0;
  logic [3:0] cnt_lo, cnt_hi;
  logic       tcu_lo, tcd_lo, tcu_hi, tcd_hi;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_cnt = 0;
  int s1_clr = 0, s1_ld = 1, s1_up = 1, s1_dn = 1;
  int s2_clr = 0, s2_ld = 1, s2_up = 1, s2_dn = 1;
  int p_up = 1, p_dn = 1;

  always #2 clk = ~clk;

  decade_updown_counter u_decade_updown_counter (
    .clk(clk), .rst(rst), .clr_i(clr), .load_n_i(load_n), .up_i(up), .dn_i(dn),
    .preset_i(preset), .count_o(cnt_lo), .tc_up_n_o(tcu_lo), .tc_dn_n_o(tcd_lo));

  decade_updown_counter u_decade_updown_counter_hi (
    .clk(clk), .rst(rst), .clr_i(clr), .load_n_i(load_n), .up_i(tcu_lo), .dn_i(tcd_lo),
    .preset_i(preset), .count_o(cnt_hi), .tc_up_n_o(tcu_hi), .tc_dn_n_o(tcd_hi));

  function automatic int up_next(int v);
    if (v == 9) return 0;
    if (v == 11) return 6;
    if (v == 13) return 4;
    if (v == 15) return 2;
    return v + 1;
  endfunction

  function automatic int dn_next(int v);
    return (v == 0) ? 9 : v - 1;
  endfunction

  task automatic model_edge();
    bit ur, dr;
    if (rst) begin
      m_cnt = 0; s1_clr = 0; s1_ld = 1; s1_up = 1; s1_dn = 1;
      s2_clr = 0; s2_ld = 1; s2_up = 1; s2_dn = 1; p_up = 1; p_dn = 1;
      return;
    end
    ur = (s2_up == 1) && (p_up == 0);
    dr = (s2_dn == 1) && (p_dn == 0);
    if (s2_clr == 1) m_cnt = 0;
    else if (s2_ld == 0) m_cnt = int'(preset);
    else if (ur && !dr && s2_dn == 1) m_cnt = up_next(m_cnt);
    else if (dr && !ur && s2_up == 1) m_cnt = dn_next(m_cnt);
    p_up = s2_up; p_dn = s2_dn;
    s2_clr = s1_clr; s2_ld = s1_ld; s2_up = s1_up; s2_dn = s1_dn;
    s1_clr = int'(clr); s1_ld = int'(load_n); s1_up = int'(up); s1_dn = int'(dn);
  endtask

  task automatic compare();
    int e_tcu, e_tcd;
    e_tcu = (s2_up == 0 && (m_cnt % 2 == 1) && m_cnt >= 8) ? 0 : 1;
    e_tcd = (s2_dn == 0 && m_cnt == 0) ? 0 : 1;
    vectors++;
    if (int'(cnt_lo) != m_cnt || int'(tcu_lo) != e_tcu || int'(tcd_lo) != e_tcd) begin
      fails++;
      $display("FAIL %s: count/tcu/tcd = %0d/%0d/%0d expected %0d/%0d/%0d",
               cur_req, cnt_lo, tcu_lo, tcd_lo, m_cnt, e_tcu, e_tcd);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      if (!rst) compare();
    end
  endtask

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_up();
    up = 1'b0; tick(4); up = 1'b1; tick(4);
  endtask

  task automatic pulse_dn();
    dn = 1'b0; tick(4); dn = 1'b1; tick(4);
  endtask

  task automatic load(int v);
    preset = 4'(v); load_n = 1'b0; tick(4); load_n = 1'b1; tick(4);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1; tick(4); rst = 1'b0;
    // R1: reset state
    cur_req = "R1";
    check("R1", int'(cnt_lo), 0);
    check("R1", int'(tcu_lo), 1);
    check("R1", int'(tcd_lo), 1);
    tick(2);

    // R2: count up through the decade and wrap
    cur_req = "R2";
    for (int k = 0; k < 12; k++) pulse_up();
    check("R2", int'(cnt_lo), 2);

    // R3: count down and wrap below zero
    cur_req = "R3";
    for (int k = 0; k < 5; k++) pulse_dn();
    check("R3", int'(cnt_lo), 7);

    // R4: no step while the other input is low; simultaneous rise holds
    cur_req = "R4";
    dn = 1'b0; tick(4);
    pulse_up();
    check("R4", int'(cnt_lo), 7);
    dn = 1'b1; tick(6);
    check("R4", int'(cnt_lo), 6);
    up = 1'b0; dn = 1'b0; tick(5);
    up = 1'b1; dn = 1'b1; tick(6);
    check("R4", int'(cnt_lo), 6);

    // R12: latency of three edges
    cur_req = "R12";
    up = 1'b0; tick(5);
    up = 1'b1;
    tick(2);
    check("R12", int'(cnt_lo), 6);
    tick(1);
    check("R12", int'(cnt_lo), 7);
    tick(4);

    // R5: clear beats load and counting
    cur_req = "R5";
    preset = 4'd8; load_n = 1'b0; clr = 1'b1; up = 1'b0; tick(4);
    up = 1'b1; tick(4);
    check("R5", int'(cnt_lo), 0);
    clr = 1'b0; load_n = 1'b1; tick(4);

    // R6: load beats counting
    cur_req = "R6";
    preset = 4'd5; load_n = 1'b0; tick(4);
    up = 1'b0; tick(4); up = 1'b1; tick(4);
    check("R6", int'(cnt_lo), 5);
    load_n = 1'b1; tick(4);
    check("R6", int'(cnt_lo), 5);

    // R7: escape upward from codes 10..15
    cur_req = "R7";
    load(10); pulse_up(); check("R7", int'(cnt_lo), 11); pulse_up(); check("R7", int'(cnt_lo), 6);
    load(12); pulse_up(); pulse_up(); check("R7", int'(cnt_lo), 4);
    load(14); pulse_up(); check("R7", int'(cnt_lo), 15); pulse_up(); check("R7", int'(cnt_lo), 2);

    // R8: walk down from 15
    cur_req = "R8";
    load(15);
    for (int k = 0; k < 6; k++) pulse_dn();
    check("R8", int'(cnt_lo), 9);
    pulse_dn();
    check("R8", int'(cnt_lo), 8);

    // R9: up terminal count
    cur_req = "R9";
    load(9);
    up = 1'b0; tick(4);
    check("R9", int'(tcu_lo), 0);
    up = 1'b1; tick(4);
    check("R9", int'(tcu_lo), 1);
    check("R9", int'(cnt_lo), 0);

    // R10: down terminal count
    cur_req = "R10";
    dn = 1'b0; tick(4);
    check("R10", int'(tcd_lo), 0);
    dn = 1'b1; tick(4);
    check("R10", int'(tcd_lo), 1);
    check("R10", int'(cnt_lo), 9);

    // R11: two-digit cascade
    cur_req = "R11";
    clr = 1'b1; tick(5); clr = 1'b0; tick(5);
    for (int k = 0; k < 25; k++) pulse_up();
    tick(6);
    check("R11", int'(cnt_hi) * 10 + int'(cnt_lo), 25);
    for (int k = 0; k < 30; k++) pulse_dn();
    tick(6);
    check("R11", int'(cnt_hi) * 10 + int'(cnt_lo), ((25 - 30) + 100) % 100);
    for (int k = 0; k < 7; k++) pulse_up();
    tick(6);
    check("R11", int'(cnt_hi) * 10 + int'(cnt_lo), 2);

    done = 1;
    summary();
    $finish;
  end
endmodule